// File: doc/BRIEF.md
# Sensor Interrupt Routing Controller

This block gathers the event flags raised by six detection sources of a motion sensor (auto-sleep/wake change, transient, orientation, pulse, freefall/motion and data-ready) and turns them into two interrupt lines. Each event pulse sets a pending bit. The pending bit stays set until the host reads that source's status register, which produces a clear strobe. The host can read the pending vector to learn which sources fired.

Each source has two configuration bits. The enable bit decides whether the source can reach a line at all. The route bit decides which of the two lines it reaches. Each line is the OR of the enabled pending sources routed to it. One polarity bit and one drive-mode bit apply to both lines. Push-pull drives the pin at all times. Open-drain drives the pin only while it is asserted, so several devices can share one wire. The line outputs are registered.

Top module: `irq_route_ctrl`

## Requirements
- R1: Pending bit i is set at the clock edge where event input i is high. Bit positions are: 0 data-ready, 1 freefall/motion, 2 pulse, 3 orientation, 4 transient, 5 auto-sleep/wake. A pending bit with no set and no clear keeps its value. Pending bits latch whether or not the source is enabled.
- R2: A clear strobe on source i clears pending bit i at the next edge. If set and clear arrive in the same cycle, the bit ends up set.
- R3: A source whose enable bit is 0 never asserts either line. All enable bits are 0 after reset.
- R4: A source with route bit 1 goes to line 1 only. A source with route bit 0 goes to line 2 only. All route bits are 0 after reset.
- R5: Each line is asserted when at least one enabled pending source is routed to it. The line stays asserted while any such source remains pending.
- R6: With the polarity bit at 0, an asserted line has value 0. With the polarity bit at 1, an asserted line has value 1.
- R7: In push-pull mode (drive bit 0), the output-enable is always 1. The value is the active level when the line is asserted and the inverse of the active level otherwise.
- R8: In open-drain mode (drive bit 1), the output-enable is 1 only while the line is asserted. The value output always carries the active level.
- R9: The line outputs change one clock after a change in pending state or configuration. An event that sets a pending bit at edge k shows on a line at edge k+1.
- R10: After reset, all pending bits are 0. Both lines show value 1 with output-enable 1, which is idle for active-low push-pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | N_SRC | Per-source event pulses |
| clr_strobe | input | N_SRC | Per-source clear strobes from a status read |
| cfg_enable | input | N_SRC | Per-source enable bits |
| cfg_route | input | N_SRC | Per-source line select (1 = line 1, 0 = line 2) |
| cfg_act_high | input | 1 | Polarity of both lines (1 = active-high) |
| cfg_open_drain | input | 1 | Drive mode of both lines (1 = open-drain) |
| irq_line1_val | output | 1 | Line 1 drive value |
| irq_line1_oe | output | 1 | Line 1 output-enable |
| irq_line2_val | output | 1 | Line 2 drive value |
| irq_line2_oe | output | 1 | Line 2 output-enable |
| src_pending | output | N_SRC | Pending status vector |

## Verification
Two events can fall in the same cycle: a source's event pulse and the clear strobe from a read of its status. This cycle decides whether the bit survives and whether the line stays asserted. The bench provokes the collision directly on one source. Sparse random event and clear vectors then make it happen many times on all sources, often while configuration also changes. Each cycle is judged by a bench model that applies clear before set and computes the lines from the pending state one edge earlier.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned SRC_COUNT = 6;

  typedef enum int unsigned {
    SRC_DATA_READY = 0,
    SRC_FREEFALL   = 1,
    SRC_TAP        = 2,
    SRC_TILT       = 3,
    SRC_SHOCK      = 4,
    SRC_SLEEPWAKE  = 5
  } src_idx_e;

  typedef struct packed {
    logic val;
    logic oe;
  } pin_drive_t;

  // Pin drive for one line from its asserted state and the shared config.
  function automatic pin_drive_t drive_of(logic asserted, logic act_high,
                                          logic open_drain);
    pin_drive_t d;
    if (open_drain) begin
      d.val = act_high;
      d.oe  = asserted;
    end else begin
      d.val = asserted ? act_high : ~act_high;
      d.oe  = 1'b1;
    end
    return d;
  endfunction

  // Idle drive produced by the reset configuration (active-low push-pull).
  localparam pin_drive_t DRIVE_RESET = '{val: 1'b1, oe: 1'b1};

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_o[g] <= 1'b0;
      end else if (set_i[g]) begin
        pend_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        pend_o[g] <= 1'b0;
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_o[g]); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R2
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> $stable(pend_o[g])); // R1
  end

endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux #(
  parameter int unsigned N_SRC = 6
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] route_i,
  output logic             req_line1_o,
  output logic             req_line2_o
);

  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] to_line1;
  logic [N_SRC-1:0] to_line2;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign live[g]     = pend_i[g] & en_i[g];
    assign to_line1[g] = live[g] &  route_i[g];
    assign to_line2[g] = live[g] & ~route_i[g];
  end

  assign req_line1_o = |to_line1;
  assign req_line2_o = |to_line2;

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
  import irq_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic act_high_i,
  input  logic open_drain_i,
  output logic val_o,
  output logic oe_o
);

  pin_drive_t next_drive;
  pin_drive_t drive_q;

  assign next_drive = drive_of(req_i, act_high_i, open_drain_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= DRIVE_RESET;
    else        drive_q <= next_drive;
  end

  assign val_o = drive_q.val;
  assign oe_o  = drive_q.oe;

  AST_PP_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !open_drain_i |=> oe_o); // R7
  AST_OD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (open_drain_i && !req_i) |=> !oe_o); // R8
  AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (oe_o && (val_o == $past(act_high_i)))); // R6

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_pulse,
  input  logic [N_SRC-1:0] clr_strobe,
  input  logic [N_SRC-1:0] cfg_enable,
  input  logic [N_SRC-1:0] cfg_route,
  input  logic             cfg_act_high,
  input  logic             cfg_open_drain,
  output logic             irq_line1_val,
  output logic             irq_line1_oe,
  output logic             irq_line2_val,
  output logic             irq_line2_oe,
  output logic [N_SRC-1:0] src_pending
);

  localparam int unsigned N_LINES = 2;

  logic [N_SRC-1:0]   pend;
  logic [N_LINES-1:0] line_req;
  logic [N_LINES-1:0] line_val;
  logic [N_LINES-1:0] line_oe;

  irq_pending_bank #(.N_SRC(N_SRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse),
    .clr_i  (clr_strobe),
    .pend_o (pend)
  );

  irq_line_mux #(.N_SRC(N_SRC)) u_mux (
    .pend_i      (pend),
    .en_i        (cfg_enable),
    .route_i     (cfg_route),
    .req_line1_o (line_req[0]),
    .req_line2_o (line_req[1])
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    irq_pin_driver u_drv (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (line_req[l]),
      .act_high_i   (cfg_act_high),
      .open_drain_i (cfg_open_drain),
      .val_o        (line_val[l]),
      .oe_o         (line_oe[l])
    );
  end

  assign irq_line1_val = line_val[0];
  assign irq_line1_oe  = line_oe[0];
  assign irq_line2_val = line_val[1];
  assign irq_line2_oe  = line_oe[1];
  assign src_pending   = pend;

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_pending & cfg_enable) == '0) |=>
      ((!irq_line1_oe || irq_line1_val != $past(cfg_act_high)) &&
       (!irq_line2_oe || irq_line2_val != $past(cfg_act_high)))); // R3
  AST_ROUTE_LINE1: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_pending & cfg_enable & cfg_route) != '0) |=>
      (irq_line1_oe && irq_line1_val == $past(cfg_act_high))); // R4
  AST_ROUTE_LINE2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_pending & cfg_enable & ~cfg_route) != '0) |=>
      (irq_line2_oe && irq_line2_val == $past(cfg_act_high))); // R4

endmodule

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
  import irq_route_pkg::*;

  localparam int unsigned NS = SRC_COUNT;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [NS-1:0] evt, clr, en, route;
  logic          hi, od;
  logic          v1, o1, v2, o2;
  logic [NS-1:0] pend;

  irq_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .clr_strobe(clr),
    .cfg_enable(en), .cfg_route(route), .cfg_act_high(hi),
    .cfg_open_drain(od), .irq_line1_val(v1), .irq_line1_oe(o1),
    .irq_line2_val(v2), .irq_line2_oe(o2), .src_pending(pend)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  logic [NS-1:0] m_pend;
  logic [1:0]    m_l1, m_l2;

  // Returns {val, oe}.
  function automatic logic [1:0] exp_pin(logic hit, logic act_hi, logic odm);
    logic asserted_level;
    asserted_level = act_hi;
    if (odm) return {asserted_level, hit};
    return {hit ~^ act_hi, 1'b1};
  endfunction

  function automatic logic line_hit(logic [NS-1:0] p, logic [NS-1:0] e,
                                    logic [NS-1:0] r, bit first);
    for (int i = 0; i < NS; i++)
      if (p[i] && e[i] && (r[i] == first)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [NS-1:0] e, logic [NS-1:0] c);
    @(negedge clk);
    evt = e;
    clr = c;
    @(posedge clk);
    #1;
    m_l1   = exp_pin(line_hit(m_pend, en, route, 1'b1), hi, od);
    m_l2   = exp_pin(line_hit(m_pend, en, route, 1'b0), hi, od);
    m_pend = (m_pend & ~c) | e;
    check("R1/R2", "pending", 8'(pend), 8'(m_pend));
    check("R5/R9", "line1", {6'd0, v1, o1}, {6'd0, m_l1});
    check("R5/R9", "line2", {6'd0, v2, o2}, {6'd0, m_l2});
  endtask

  function automatic logic [NS-1:0] bitm(int i);
    return NS'(1) << i;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; clr = '0; en = '0; route = '0; hi = 1'b0; od = 1'b0;
    m_pend = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10", "pending", 8'(pend), 8'h00);
    check("R10", "line1", {6'd0, v1, o1}, 8'h03);
    check("R10", "line2", {6'd0, v2, o2}, 8'h03);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: everything pending, nothing enabled
    step('1, '0);
    check("R1", "all latched", 8'(pend), 8'h3f);
    step('0, '0);
    check("R3", "line1 idle", {6'd0, v1, o1}, 8'h03);
    check("R3", "line2 idle", {6'd0, v2, o2}, 8'h03);
    step('0, '1);
    check("R2", "cleared", 8'(pend), 8'h00);

    // R9 and R4: orientation routed to line 2
    @(negedge clk); en = bitm(SRC_TILT); route = '0;
    step(bitm(SRC_TILT), '0);
    check("R9", "line2 not yet", {6'd0, v2, o2}, 8'h03);
    step('0, '0);
    check("R4", "line2 asserted low", {6'd0, v2, o2}, 8'h01);
    check("R4", "line1 idle", {6'd0, v1, o1}, 8'h03);
    @(negedge clk); route = bitm(SRC_TILT);
    step('0, '0);
    check("R4", "line1 asserted", {6'd0, v1, o1}, 8'h01);
    check("R4", "line2 idle", {6'd0, v2, o2}, 8'h03);

    // R5: two sources on line 1, clear one
    @(negedge clk); en = bitm(SRC_TILT) | bitm(SRC_TAP); route = en;
    step(bitm(SRC_TAP), bitm(SRC_TILT));
    step('0, '0);
    check("R5", "line1 held by other", {6'd0, v1, o1}, 8'h01);

    // R2: set and clear together
    step(bitm(SRC_SHOCK), bitm(SRC_SHOCK));
    check("R2", "set wins", 8'(pend[SRC_SHOCK]), 8'h01);
    step('0, bitm(SRC_SHOCK) | bitm(SRC_TAP));
    check("R2", "clear alone", 8'(pend), 8'h00);

    // R6 active-high, R7 push-pull idle
    @(negedge clk); hi = 1'b1; en = bitm(SRC_DATA_READY); route = '0;
    step(bitm(SRC_DATA_READY), '0);
    step('0, '0);
    check("R6", "line2 high", {6'd0, v2, o2}, 8'h03);
    check("R7", "line1 driven low idle", {6'd0, v1, o1}, 8'h01);

    // R8 open drain
    @(negedge clk); od = 1'b1;
    step('0, bitm(SRC_DATA_READY));
    check("R8", "asserted drives", {6'd0, v2, o2}, 8'h03);
    check("R8", "idle released", 8'(o1), 8'h00);
    step('0, '0);
    check("R8", "released after clear", 8'(o2), 8'h00);

    // Random phase, fixed seed
    void'($urandom(32'd4242));
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 16) == 0) begin
        @(negedge clk);
        en = NS'($urandom); route = NS'($urandom);
        hi = 1'($urandom); od = 1'($urandom);
      end
      step(NS'($urandom & $urandom & $urandom),
           NS'($urandom & $urandom));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule